// File: doc/BRIEF.md
# Prioritized Interrupt Controller with In-Service Latches

This block arbitrates the six interrupt sources of a two-channel serial controller. The sources are receive, transmit and external/status for channel A and for channel B. Each source's raw condition is masked by its own enable and registered as a pending bit. The block drives an active-low interrupt request whenever a pending source outranks everything already in service. It also drives a daisy-chain enable output that keeps lower-priority devices quiet while this block is requesting or servicing.

An acknowledge comes either from a hardware strobe or from a read of the vector register while the software-acknowledge enable is set. It latches the winning source as in service, which removes that source's request. The in-service latch holds until software issues a reset-highest command, and that command releases only the highest-priority latch that is set. A vector read through channel A returns the programmed base byte unchanged. A read through channel B replaces a 3-bit field of the base with a code that names the winning source, including whether a receive interrupt is a special condition.

Top module: `sio_irq_ctrl`

## Requirements
- R1: Priority from highest to lowest is source index 0 to 5: A receive, A transmit, A external/status, B receive, B transmit, B external/status. Only the highest-priority requesting source wins.
- R2: A source's pending bit is its raw condition ANDed with its enable, registered one clock after the inputs are presented. A disabled source never requests.
- R3: int_n is low exactly when ien_in is high and some pending source has no in-service latch set at its own or a higher priority. ien_out is low whenever int_n is low or any latch is set.
- R4: An acknowledge is a hw_ack pulse, or a vec_rd pulse while sw_ack_en is high. When int_n is low, it sets the in-service latch of the winning source only, on the following clock. Otherwise it sets nothing.
- R5: A vec_rd pulse while sw_ack_en is low leaves every in-service latch unchanged.
- R6: A rst_ius pulse clears only the lowest-index set latch. With no latch set, it has no effect.
- R7: With no acknowledge and no rst_ius, the latches hold their value. A set latch blocks requests from its own source and all lower-priority sources, but not from higher-priority ones.
- R8: While ien_in is low, int_n stays high, ien_out stays low, and acknowledges set no latch.
- R9: A vec_rd pulse loads vec_out on the next clock. Through channel A (vec_chan_b = 0) it returns vec_base raw. Through channel B it returns vec_base with bits [3:1] replaced by the winning source's code, or raw when nothing requests. The codes are: A tx 4, A ext 5, A rx 6, B tx 0, B ext 1, B rx 2.
- R10: When the winner is a receive source and that channel's rx_special bit (bit 0 for A, bit 1 for B) is high, the code is 7 for A and 3 for B.
- R11: After reset, int_n is high, all latches are clear, and vec_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 6 | Raw interrupt conditions, index 0 highest priority |
| src_en | input | 6 | Per-source interrupt enables |
| rx_special | input | 2 | Receive special-condition flag per channel (bit 0 A, bit 1 B) |
| ien_in | input | 1 | Daisy-chain enable from upstream |
| hw_ack | input | 1 | Hardware acknowledge pulse |
| vec_rd | input | 1 | Vector register read pulse |
| vec_chan_b | input | 1 | Vector read goes through channel B when high |
| sw_ack_en | input | 1 | A vector read also acknowledges when high |
| rst_ius | input | 1 | Reset-highest-in-service command pulse |
| vec_base | input | 8 | Programmed base vector |
| int_n | output | 1 | Active-low interrupt request |
| ien_out | output | 1 | Daisy-chain enable to downstream |
| vec_out | output | 8 | Vector returned by the last read |
| ius | output | 6 | In-service latches |

## Verification
The latch assertions assume that an acknowledge and a reset-highest command never arrive in the same cycle, and that hw_ack, vec_rd and rst_ius are single-cycle pulses. The vector assertion assumes vec_base does not change in the cycle of a read. The stimulus drives every input on the falling edge, raises each command alone for one cycle, and changes the base only while no read is in flight.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NSRC   = 6;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int CODE_W = 3;

  // Source code reported through the modified vector
  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx,
                                                 input logic special);
    logic [CODE_W-1:0] c;
    case (idx)
      3'd0:    c = special ? 3'd7 : 3'd6;
      3'd1:    c = 3'd4;
      3'd2:    c = 3'd5;
      3'd3:    c = special ? 3'd3 : 3'd2;
      3'd4:    c = 3'd0;
      default: c = 3'd1;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] blk,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N-1:0] shut;
  logic [N-1:0] ok;
  logic [N-1:0] taken;

  generate
    for (genvar k = 0; k < N; k++) begin : g_chain
      if (k == 0) begin : g_first
        assign shut[k]  = blk[k];
        assign ok[k]    = req[k] & ~shut[k];
        assign grant[k] = ok[k];
        assign taken[k] = ok[k];
      end else begin : g_rest
        assign shut[k]  = shut[k-1] | blk[k];
        assign ok[k]    = req[k] & ~shut[k];
        assign grant[k] = ok[k] & ~taken[k-1];
        assign taken[k] = taken[k-1] | ok[k];
      end
    end
  endgenerate

  assign any = taken[N-1];

  always_comb begin
    p_single_grant_r1: assert ($onehot0(grant)) else $error("grant not one-hot");
  end
endmodule

// File: rtl/sio_irq_ius.sv
module sio_irq_ius #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_vec,
  input  logic         clr_en,
  output logic [N-1:0] ius_q
);
  logic [N-1:0] ius_d;
  logic [N-1:0] lowest;
  logic         ius_ce;

  assign lowest = ius_q & (~ius_q + N'(1));
  assign ius_ce = set_en | clr_en;

  always_comb begin
    ius_d = ius_q;
    if (clr_en) ius_d = ius_d & ~lowest;
    if (set_en) ius_d = ius_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ius_q <= '0;
    else if (ius_ce) ius_q <= ius_d;
  end

  p_ack_sets_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ($countones(ius_q & ~$past(ius_q)) == 1));

  p_clear_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && (ius_q != '0)) |=> ($countones($past(ius_q) & ~ius_q) == 1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(ius_q));
endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec #(
  parameter int VW  = 8,
  parameter int CW  = 3,
  parameter int LSB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          chan_b,
  input  logic          any,
  input  logic [CW-1:0] code,
  input  logic [VW-1:0] base,
  output logic [VW-1:0] vec_q
);
  logic [VW-1:0] vec_d;

  always_comb begin
    vec_d = base;
    if (chan_b && any) vec_d[LSB +: CW] = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vec_q <= '0;
    else if (rd) vec_q <= vec_d;
  end

  p_chan_a_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !chan_b) |=> (vec_q == $past(base)));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int CODE_LSB = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic [NSRC-1:0]  src_en,
  input  logic [1:0]       rx_special,
  input  logic             ien_in,
  input  logic             hw_ack,
  input  logic             vec_rd,
  input  logic             vec_chan_b,
  input  logic             sw_ack_en,
  input  logic             rst_ius,
  input  logic [VEC_W-1:0] vec_base,
  output logic             int_n,
  output logic             ien_out,
  output logic [VEC_W-1:0] vec_out,
  output logic [NSRC-1:0]  ius
);
  localparam int HALF = NSRC / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  // pending bits
  logic [NSRC-1:0] ip_q;
  logic [NSRC-1:0] ip_d;
  assign ip_d = src_req & src_en;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ip_q <= '0;
    else          ip_q <= ip_d;
  end

  // arbitration
  logic [NSRC-1:0] grant;
  logic            any_req;
  sio_irq_prio #(.N(NSRC)) u_prio (
    .req  (ip_q),
    .blk  (ius),
    .grant(grant),
    .any  (any_req)
  );

  logic [IDX_W-1:0] win_idx;
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) win_idx = IDX_W'(i);
  end

  logic             win_chan_b;
  logic [CODE_W-1:0] win_code;
  assign win_chan_b = (win_idx >= IDX_W'(HALF));
  assign win_code   = src_code(win_idx, rx_special[win_chan_b]);

  logic int_req;
  logic ack_cmd;
  logic ack_fire;
  assign int_req  = ien_in & any_req;
  assign ack_cmd  = hw_ack | (vec_rd & sw_ack_en);
  assign ack_fire = ack_cmd & int_req;

  sio_irq_ius #(.N(NSRC)) u_ius (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_en (ack_fire),
    .set_vec(grant),
    .clr_en (rst_ius),
    .ius_q  (ius)
  );

  sio_irq_vec #(.VW(VEC_W), .CW(CODE_W), .LSB(CODE_LSB)) u_vec (
    .clk   (clk),
    .rst_n (rst_s_n),
    .rd    (vec_rd),
    .chan_b(vec_chan_b),
    .any   (int_req),
    .code  (win_code),
    .base  (vec_base),
    .vec_q (vec_out)
  );

  assign int_n   = ~int_req;
  assign ien_out = ien_in & ~int_req & ~(|ius);

  p_chain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ien_in |-> (int_n && !ien_out));

  p_top_in_service_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    ius[0] |-> int_n);

  p_plain_read_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (vec_rd && !sw_ack_en && !hw_ack && !rst_ius) |=> $stable(ius));
endmodule

// File: tb/tb_sio_irq_ctrl.sv
module tb_sio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_req, src_en, ius;
  logic [1:0] rx_special;
  logic       ien_in, hw_ack, vec_rd, vec_chan_b, sw_ack_en, rst_ius;
  logic [7:0] vec_base, vec_out;
  logic       int_n, ien_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .rx_special(rx_special), .ien_in(ien_in), .hw_ack(hw_ack),
    .vec_rd(vec_rd), .vec_chan_b(vec_chan_b), .sw_ack_en(sw_ack_en),
    .rst_ius(rst_ius), .vec_base(vec_base), .int_n(int_n),
    .ien_out(ien_out), .vec_out(vec_out), .ius(ius)
  );

  // {req, en, ien_in, exp_int_n, exp_ien_out}
  localparam logic [14:0] TBL [7] = '{
    15'b000000_111111_1_1_1,
    15'b001000_111111_1_0_0,
    15'b001000_110111_1_1_1,
    15'b000001_111111_0_1_0,
    15'b111111_000000_1_1_1,
    15'b010000_111111_1_0_0,
    15'b100000_011111_1_1_1
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ack();
    hw_ack = 1'b1; step(); hw_ack = 1'b0;
  endtask

  task automatic pulse_rst();
    rst_ius = 1'b1; step(); rst_ius = 1'b0;
  endtask

  task automatic read_vec(input logic chan_b);
    vec_chan_b = chan_b; vec_rd = 1'b1; step(); vec_rd = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; src_en = '1; rx_special = '0; ien_in = 1'b1;
    hw_ack = 0; vec_rd = 0; vec_chan_b = 0; sw_ack_en = 0; rst_ius = 0;
    vec_base = 8'hA1;
    step(); step();
    // R11 reset state
    chk("R11 int_n", {7'd0, int_n}, 8'd1);
    chk("R11 ius", {2'd0, ius}, 8'd0);
    chk("R11 vec_out", vec_out, 8'h00);
    rst_n = 1'b1;
    step(); step(); step();

    // R2/R3/R8 table walk
    for (int i = 0; i < 7; i++) begin
      src_req = TBL[i][14:9]; src_en = TBL[i][8:3]; ien_in = TBL[i][2];
      step();
      chk("R3 int_n table", {7'd0, int_n}, {7'd0, TBL[i][1]});
      chk("R3 ien_out table", {7'd0, ien_out}, {7'd0, TBL[i][0]});
    end
    src_en = '1; ien_in = 1'b1;

    // R1/R9/R5: plain reads
    src_req = 6'b001010; step();
    chk("R3 pending", {7'd0, int_n}, 8'd0);
    read_vec(1'b1);
    chk("R9 chan B A-tx code", vec_out, 8'hA9);
    chk("R5 no ack on plain read", {2'd0, ius}, 8'd0);
    read_vec(1'b0);
    chk("R9 chan A raw", vec_out, 8'hA1);

    // R4 software acknowledge
    sw_ack_en = 1'b1; read_vec(1'b1); sw_ack_en = 1'b0;
    chk("R4 sw ack vector", vec_out, 8'hA9);
    chk("R4 sw ack latch", {2'd0, ius}, 8'h02);
    chk("R7 blocked lower", {7'd0, int_n}, 8'd1);
    chk("R3 ien_out in service", {7'd0, ien_out}, 8'd0);

    // R7 higher source preempts, R4 hw ack
    src_req = 6'b001011; step();
    chk("R7 higher preempts", {7'd0, int_n}, 8'd0);
    pulse_ack();
    chk("R4 hw ack latch", {2'd0, ius}, 8'h03);
    step(); step();
    chk("R7 hold", {2'd0, ius}, 8'h03);

    // R6 reset highest
    src_req = 6'b001010; step();
    pulse_rst();
    chk("R6 clear highest", {2'd0, ius}, 8'h02);
    chk("R7 still blocked", {7'd0, int_n}, 8'd1);
    pulse_rst();
    chk("R6 clear next", {2'd0, ius}, 8'h00);
    chk("R3 request again", {7'd0, int_n}, 8'd0);
    pulse_rst();
    chk("R6 none set", {2'd0, ius}, 8'h00);

    // R10/R1 codes
    src_req = 6'b000001; rx_special = 2'b01; step();
    read_vec(1'b1);
    chk("R10 A rx special", vec_out, 8'hAF);
    rx_special = 2'b00; read_vec(1'b1);
    chk("R1 A rx code", vec_out, 8'hAD);
    src_req = 6'b001000; rx_special = 2'b10; step();
    read_vec(1'b1);
    chk("R10 B rx special", vec_out, 8'hA7);
    src_req = 6'b100000; rx_special = 2'b00; step();
    read_vec(1'b1);
    chk("R9 B ext code", vec_out, 8'hA3);
    src_req = 6'b000000; step();
    read_vec(1'b1);
    chk("R9 none raw", vec_out, 8'hA1);

    // R8 chain disabled ignores ack
    ien_in = 1'b0; src_req = 6'b000010; step();
    chk("R8 int_n", {7'd0, int_n}, 8'd1);
    chk("R8 ien_out", {7'd0, ien_out}, 8'd0);
    pulse_ack();
    chk("R8 ack ignored", {2'd0, ius}, 8'h00);
    ien_in = 1'b1; step();
    chk("R3 resumes", {7'd0, int_n}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule